// File: doc/BRIEF.md
# Dual-Mode Programmable Feedback Divider

This block is the feedback divider of a channelized frequency synthesizer. It divides its input clock by a ratio N and emits one single-cycle pulse every N input cycles. The ratio comes from an 8-bit program word. A mode input selects how that word is read.

In binary mode the word is taken as a plain unsigned ratio. In channel mode only the low six bits count. The low four bits carry a units digit and the next two bits add ten and twenty. A fixed offset of 90 is then added. The same six-bit pattern therefore gives different ratios in the two modes. In channel mode a legality flag is raised whenever the pattern does not select one of the forty permitted channel ratios.

The divider is a down-counter. It loads N-1 at terminal count and reloads on the same edge. A new program or mode takes effect only at the next terminal count, so no period ever runs at a mixed ratio.

Top module: `fbdiv_top`

## Requirements
- R1: `mode_chan` high selects channel mode and low selects binary mode; the mode in force at a terminal count sets the ratio of the period that follows.
- R2: In binary mode N equals the unsigned value of `prog[7:0]`, with `prog[0]` as the least significant bit, so the pulse period is N clocks for every N from 3 to 255.
- R3: In binary mode a program value of 0, 1 or 2 is clamped to a ratio of 3.
- R4: In channel mode N = 90 + the sum of the weights of the set bits. `prog[0]` to `prog[3]` weigh 1, 2, 4 and 8, `prog[4]` weighs 10 and `prog[5]` weighs 20. `prog[7:6]` have no effect on the ratio or on `inhibit`.
- R5: In channel mode `inhibit` is high exactly when N lies outside 91..135 or equals 94, 99, 104, 109 or 114. It follows the live inputs combinationally, so the forty legal programs give `inhibit` low.
- R6: In binary mode `inhibit` is always low.
- R7: `div_pulse` is high for exactly one clock per period, and successive rising edges of `div_pulse` are exactly N clocks apart.
- R8: A change of program or mode during a period does not alter the length of that period; the new ratio applies from the next terminal count.
- R9: While reset is active `div_pulse` is low. After `rst_n` rises, the first pulse is visible after the third rising clock edge, and the next pulse follows N clocks later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset, released through an internal synchronizer |
| mode_chan | input | 1 | 1 = channel mode, 0 = binary mode |
| prog | input | 8 | Program word; bit 0 has the lowest weight |
| div_pulse | output | 1 | One-clock pulse once per N clocks |
| inhibit | output | 1 | Channel-mode illegal-program flag |

## Verification
The assertions assume that `prog` and `mode_chan` change only between clock edges and remain at known values once reset is released. With those inputs, the decoded ratio always lies in a known span, and the counter load is never zero. The bench changes inputs only on falling clock edges and samples outputs there too. After every program change it waits for one full period before it measures, except in the test that deliberately changes the program mid-period to check that the change is deferred.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;

  typedef enum logic {
    MODE_BINARY  = 1'b0,
    MODE_CHANNEL = 1'b1
  } div_mode_e;

  // Weight of program bit idx when read as a channel code:
  // the units nibble is binary, the bits above it count in tens.
  function automatic int chan_weight(input int idx, input int units_bits);
    if (idx < units_bits) return (1 << idx);
    return 10 * (1 << (idx - units_bits));
  endfunction

endpackage

// File: rtl/fbdiv_ratio_decode.sv
module fbdiv_ratio_decode
  import fbdiv_pkg::*;
#(
  parameter int PW         = 8,
  parameter int CH_BITS    = 6,
  parameter int UNIT_BITS  = 4,
  parameter int OFFSET     = 90,
  parameter int CH_LAST    = 135,
  parameter int SKIP_FIRST = 94,
  parameter int SKIP_LAST  = 114,
  parameter int SKIP_STEP  = 5,
  parameter int MIN_N      = 3
) (
  input  logic          mode_chan,
  input  logic [PW-1:0] prog,
  output logic [PW-1:0] ratio,
  output logic          illegal
);

  localparam logic [PW-1:0] MIN_V = PW'(MIN_N);

  int  bit_w [CH_BITS];
  int  code_sum;
  int  chan_n;
  logic chan_ok;
  logic [PW-1:0] bin_ratio;

  // one weighted term per channel-code bit
  for (genvar i = 0; i < CH_BITS; i++) begin : g_weight
    assign bit_w[i] = prog[i] ? chan_weight(i, UNIT_BITS) : 0;
  end

  always_comb begin
    code_sum = 0;
    for (int i = 0; i < CH_BITS; i++) code_sum = code_sum + bit_w[i];
    chan_n = OFFSET + code_sum;
  end

  always_comb begin
    chan_ok = (chan_n > OFFSET) && (chan_n <= CH_LAST);
    if ((chan_n >= SKIP_FIRST) && (chan_n <= SKIP_LAST) &&
        (((chan_n - SKIP_FIRST) % SKIP_STEP) == 0))
      chan_ok = 1'b0;
  end

  always_comb begin
    bin_ratio = (prog < MIN_V) ? MIN_V : prog;
  end

  always_comb begin
    if (div_mode_e'(mode_chan) == MODE_CHANNEL) begin
      ratio   = PW'(chan_n);
      illegal = ~chan_ok;
    end else begin
      ratio   = bin_ratio;
      illegal = 1'b0;
    end
  end

endmodule

// File: rtl/fbdiv_counter.sv
module fbdiv_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] load_val,
  output logic          pulse
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          pulse_d;
  logic          term;

  assign term = (cnt_q == '0);

  // next state: reload N-1 at terminal count, else count down
  always_comb begin
    pulse_d = term;
    if (term) cnt_d = load_val - 1'b1;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pulse <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      pulse <= pulse_d;
    end
  end

  // R7: a pulse never lasts two clocks
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);

  // R7: between terminal counts the count drops by one per clock
  a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R8: the load value is taken only at terminal count
  a_r8_load_at_term: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |=> (cnt_q == $past(load_val) - 1'b1));

endmodule

// File: rtl/fbdiv_top.sv
module fbdiv_top #(
  parameter int PW     = 8,
  parameter int OFFSET = 90,
  parameter int MIN_N  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_chan,
  input  logic [PW-1:0] prog,
  output logic          div_pulse,
  output logic          inhibit
);

  localparam int CW = PW;

  logic          rst_s1_q, rst_s2_q;
  logic [PW-1:0] ratio;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  fbdiv_ratio_decode #(
    .PW     (PW),
    .OFFSET (OFFSET),
    .MIN_N  (MIN_N)
  ) u_decode (
    .mode_chan (mode_chan),
    .prog      (prog),
    .ratio     (ratio),
    .illegal   (inhibit)
  );

  fbdiv_counter #(
    .CW (CW)
  ) u_count (
    .clk      (clk),
    .rst_n    (rst_s2_q),
    .load_val (ratio),
    .pulse    (div_pulse)
  );

  // R6: binary mode never flags
  a_r6_no_inhibit_binary: assert property (@(posedge clk) disable iff (!rst_s2_q)
    !mode_chan |-> !inhibit);

  // R3: the counter is never loaded below the minimum ratio
  a_r3_ratio_floor: assert property (@(posedge clk) disable iff (!rst_s2_q)
    ratio >= PW'(MIN_N));

  // R4: channel ratios stay within offset .. offset+45
  a_r4_chan_span: assert property (@(posedge clk) disable iff (!rst_s2_q)
    mode_chan |-> ((ratio >= PW'(OFFSET)) && (ratio <= PW'(OFFSET + 45))));

  // R9: no pulse in the cycle after the internal reset releases
  a_r9_quiet_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_s2_q) |-> !div_pulse);

endmodule

// File: tb/fbdiv_top_tb.sv
module fbdiv_top_tb;

  logic       clk;
  logic       rst_n;
  logic       mode_chan;
  logic [7:0] prog;
  logic       div_pulse;
  logic       inhibit;

  int n_tests;
  int n_fail;

  fbdiv_top u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_chan (mode_chan),
    .prog      (prog),
    .div_pulse (div_pulse),
    .inhibit   (inhibit)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // cycles from the current pulse to the next one, sampled on falling edges
  task automatic get_period(output int p);
    int guard = 0;
    while (!div_pulse && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    p = 0;
    do begin
      @(negedge clk);
      p++;
    end while (!div_pulse && p < 1000);
  endtask

  task automatic period_after_settle(input logic m, input logic [7:0] pv, output int p);
    @(negedge clk);
    mode_chan = m;
    prog      = pv;
    get_period(p);
    get_period(p);
    get_period(p);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    mode_chan = 1'b1;
    prog = 8'h04;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R9 pulse low in reset", int'(div_pulse), 0);
    end
    check("R5 inhibit in reset for ratio 94", int'(inhibit), 1);
    prog = 8'h01;
    #1 check("R5 inhibit in reset for ratio 91", int'(inhibit), 0);
  endtask

  task automatic t_release();
    int c = 0;
    int p;
    mode_chan = 1'b0;
    prog = 8'd10;
    rst_n = 1'b1;
    do begin
      @(negedge clk);
      c++;
    end while (!div_pulse && c < 20);
    check("R9 first pulse after release", c, 3);
    get_period(p);
    check("R9 period after release", p, 10);
  endtask

  task automatic t_binary();
    int p;
    int vals [4] = '{3, 7, 200, 255};
    foreach (vals[i]) begin
      period_after_settle(1'b0, 8'(vals[i]), p);
      check("R2 binary period", p, vals[i]);
      check("R6 binary inhibit", int'(inhibit), 0);
    end
  endtask

  task automatic t_clamp();
    int p;
    for (int v = 0; v < 3; v++) begin
      period_after_settle(1'b0, 8'(v), p);
      check("R3 clamp to 3", p, 3);
    end
  endtask

  task automatic t_width();
    int hi = 0;
    period_after_settle(1'b0, 8'd9, hi);
    hi = 0;
    for (int i = 0; i < 27; i++) begin
      @(negedge clk);
      hi += int'(div_pulse);
    end
    check("R7 pulse count in 3 periods", hi, 3);
  endtask

  task automatic t_channel();
    int p;
    period_after_settle(1'b1, 8'h01, p);
    check("R4 channel 0x01", p, 91);
    period_after_settle(1'b1, 8'h3F, p);
    check("R4 channel 0x3F", p, 135);
    period_after_settle(1'b1, 8'h20, p);
    check("R4 channel 0x20", p, 110);
    period_after_settle(1'b1, 8'h10, p);
    check("R4 channel 0x10", p, 100);
    period_after_settle(1'b0, 8'h10, p);
    check("R1 same bits binary 0x10", p, 16);
    period_after_settle(1'b1, 8'hC1, p);
    check("R4 top bits ignored ratio", p, 91);
    check("R4 top bits ignored inhibit", int'(inhibit), 0);
  endtask

  task automatic t_inhibit();
    logic [7:0] bad [6]  = '{8'h00, 8'h04, 8'h09, 8'h0E, 8'h19, 8'h24};
    logic [7:0] good [5] = '{8'h01, 8'h3F, 8'h0A, 8'h05, 8'h25};
    mode_chan = 1'b1;
    foreach (bad[i]) begin
      @(negedge clk);
      prog = bad[i];
      #1 check($sformatf("R5 illegal code %0h", bad[i]), int'(inhibit), 1);
    end
    foreach (good[i]) begin
      @(negedge clk);
      prog = good[i];
      #1 check($sformatf("R5 legal code %0h", good[i]), int'(inhibit), 0);
    end
    @(negedge clk);
    mode_chan = 1'b0;
    prog = 8'h04;
    #1 check("R6 binary code 04", int'(inhibit), 0);
  endtask

  task automatic t_midchange();
    int p;
    period_after_settle(1'b0, 8'd50, p);
    p = 0;
    do begin
      @(negedge clk);
      p++;
      if (p == 10) prog = 8'd20;
    end while (!div_pulse && p < 1000);
    check("R8 period unchanged by mid change", p, 50);
    get_period(p);
    check("R8 new ratio at next period", p, 20);
    p = 0;
    do begin
      @(negedge clk);
      p++;
      if (p == 5) begin
        mode_chan = 1'b1;
        prog = 8'h01;
      end
    end while (!div_pulse && p < 1000);
    check("R1 mode change deferred", p, 20);
    get_period(p);
    check("R1 channel mode after switch", p, 91);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_tests = 0;
    n_fail = 0;
    rst_n = 1'b0;
    mode_chan = 1'b1;
    prog = 8'h04;
    t_reset();
    t_release();
    t_binary();
    t_clamp();
    t_width();
    t_channel();
    t_inhibit();
    t_midchange();
    finish_run();
  end

endmodule